// File: doc/BRIEF.md
# Flash Address Capture Unit

This block is the address entry stage of a configuration flash. It takes the parallel address bus from the host together with a latch strobe, the memory's read clock, a read-mode setting (asynchronous or synchronous), a setting that picks which edge of the read clock is used, a write indication and a phase-inhibit flag. It produces the address handed to the memory array and a one-cycle flag that marks each newly captured address.

In asynchronous operation, and for every write, the stage behaves as a level latch. It passes the bus straight through while the strobe is low and keeps the last address once the strobe goes high. In synchronous reads it ignores strobe levels for transparency. Instead it registers the bus on the selected edge of the read clock, provided the strobe is low at that edge. While the inhibit flag is raised (power-up, configuration restart, configuration readout), nothing opens and nothing is captured.

Everything is built as registers on one system clock. The latch is a hold register plus a bypass multiplexer. The read clock is sampled and its edges are detected against the previous sample. The mode settings are registered, so they take effect one system clock after they are applied.

Top module: `fac_addr_capture`

## Requirements
- R1: While reset is active and after it is released, `addr_o` reads 0 when nothing is transparent, and `addr_valid_o` is 0. Reset selects asynchronous mode with rising-edge capture.
- R2: In asynchronous mode (`sync_mode_i`=0) with `lat_en_i`=0 and `inhibit_i`=0, `addr_o` equals `addr_i` within the same cycle.
- R3: In asynchronous mode, once `lat_en_i` goes high, `addr_o` holds the address present in the last cycle the strobe was low. Later changes of `addr_i` have no effect while the strobe stays high.
- R4: With `lat_en_i` held low across many cycles, each new address flows through to `addr_o` and `addr_valid_o` stays 0.
- R5: In synchronous mode with `fall_edge_i`=0, a 0-to-1 change of the sampled `sclk_i` while `lat_en_i`=0 loads `addr_i` into the hold register, and `addr_o` shows it from the next system clock on. A 1-to-0 change loads nothing.
- R6: In synchronous mode with `fall_edge_i`=1, only a 1-to-0 change of `sclk_i` loads the address. A 0-to-1 change loads nothing.
- R7: In synchronous mode, `addr_o` never follows `addr_i` directly. Read-clock edges seen while `lat_en_i`=1 load nothing.
- R8: While `wr_op_i`=1, the synchronous setting is overridden: the stage behaves as the asynchronous latch of R2/R3, and read-clock edges load nothing.
- R9: While `inhibit_i`=1, the stage is never transparent and loads nothing in either mode, so `addr_o` keeps the held address.
- R10: `addr_valid_o` is high for exactly one cycle after each capture. That is the cycle after the first system clock that sees the strobe high following a transparent cycle, or the cycle after a loading read-clock edge. Mode settings act one system clock after they are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | AW | Address bus from the host |
| lat_en_i | input | 1 | Latch strobe: low opens/arms capture, rising closes |
| sclk_i | input | 1 | Memory read clock, sampled on `clk_i` |
| sync_mode_i | input | 1 | 1 = synchronous read mode, 0 = asynchronous |
| fall_edge_i | input | 1 | 1 = capture on falling read-clock edge, 0 = rising |
| wr_op_i | input | 1 | 1 = current bus operation is a write |
| inhibit_i | input | 1 | Power-up / restart / configuration phase active |
| addr_o | output | AW | Address presented to the memory array |
| addr_valid_o | output | 1 | One-cycle pulse after each new capture |

## Verification
Two events can coincide on the same system clock: a read-clock edge, and either a rising latch strobe or a switch to a write operation. The bench provokes this by raising the strobe, or asserting the write indication, in the same drive step that toggles the read clock into its capturing level. It judges the result by observing that `addr_o` keeps the earlier address and that no valid pulse appears. A second coincidence, a phase inhibit arriving together with a capturing edge, is checked the same way.

// File: rtl/fac_pkg.sv
package fac_pkg;

  // Registered read-mode settings
  typedef struct packed {
    logic sync_rd;    // 1: synchronous read capture
    logic fall_edge;  // 1: falling read-clock edge captures
  } fac_cfg_t;

  localparam fac_cfg_t FAC_CFG_RESET = '{sync_rd: 1'b0, fall_edge: 1'b0};

endpackage

// File: rtl/fac_rst_sync.sv
module fac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[s] <= 1'b0;
          else         chain_q[s] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[s] <= 1'b0;
          else         chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign rst_sync_no = chain_q[STAGES-1];

endmodule

// File: rtl/fac_edge_sampler.sv
module fac_edge_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic rise_o,
  output logic fall_o
);

  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
  assign fall_o = ~level_i & prev_q;

endmodule

// File: rtl/fac_capture_ctrl.sv
module fac_capture_ctrl
  import fac_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  fac_cfg_t cfg_i,
  input  logic     lat_en_i,
  input  logic     wr_op_i,
  input  logic     inhibit_i,
  input  logic     sclk_rise_i,
  input  logic     sclk_fall_i,
  output logic     open_o,
  output logic     load_o,
  output logic     valid_o
);

  logic sync_eff;
  logic edge_hit;
  logic sync_cap;
  logic async_cap;
  logic open_q, open_d;
  logic valid_q, valid_d;

  always_comb begin
    sync_eff  = cfg_i.sync_rd & ~wr_op_i;
    edge_hit  = cfg_i.fall_edge ? sclk_fall_i : sclk_rise_i;
    open_d    = ~sync_eff & ~lat_en_i & ~inhibit_i;
    sync_cap  = sync_eff & edge_hit & ~lat_en_i & ~inhibit_i;
    async_cap = ~sync_eff & open_q & lat_en_i;
    valid_d   = async_cap | sync_cap;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      open_q  <= open_d;
      valid_q <= valid_d;
    end
  end

  assign open_o  = open_d;
  assign load_o  = open_d | sync_cap;
  assign valid_o = valid_q;

  // R10
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);

  // R9
  inhibit_noload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_i |-> !load_o);

endmodule

// File: rtl/fac_addr_hold.sv
module fac_addr_hold #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          open_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] hold_o,
  output logic [AW-1:0] addr_o
);

  logic [AW-1:0] hold_q, hold_d;

  always_comb begin
    hold_d = hold_q;
    if (load_i) hold_d = addr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= '0;
    else         hold_q <= hold_d;
  end

  assign hold_o = hold_q;
  assign addr_o = open_i ? addr_i : hold_q;

endmodule

// File: rtl/fac_addr_capture.sv
module fac_addr_capture
  import fac_pkg::*;
#(
  parameter int AW        = 16,
  parameter int RST_SYNCS = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          lat_en_i,
  input  logic          sclk_i,
  input  logic          sync_mode_i,
  input  logic          fall_edge_i,
  input  logic          wr_op_i,
  input  logic          inhibit_i,
  output logic [AW-1:0] addr_o,
  output logic          addr_valid_o
);

  logic          rst_n;
  logic          sclk_rise, sclk_fall;
  logic          open, load;
  logic [AW-1:0] hold;
  fac_cfg_t      cfg_q, cfg_d;

  fac_rst_sync #(.STAGES(RST_SYNCS)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  always_comb begin
    cfg_d.sync_rd   = sync_mode_i;
    cfg_d.fall_edge = fall_edge_i;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) cfg_q <= FAC_CFG_RESET;
    else        cfg_q <= cfg_d;
  end

  fac_edge_sampler u_sclk (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .level_i (sclk_i),
    .rise_o  (sclk_rise),
    .fall_o  (sclk_fall)
  );

  fac_capture_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .cfg_i       (cfg_q),
    .lat_en_i    (lat_en_i),
    .wr_op_i     (wr_op_i),
    .inhibit_i   (inhibit_i),
    .sclk_rise_i (sclk_rise),
    .sclk_fall_i (sclk_fall),
    .open_o      (open),
    .load_o      (load),
    .valid_o     (addr_valid_o)
  );

  fac_addr_hold #(.AW(AW)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .load_i (load),
    .open_i (open),
    .addr_i (addr_i),
    .hold_o (hold),
    .addr_o (addr_o)
  );

  // R9
  inhibit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    inhibit_i |=> $stable(hold));

  // R7
  sync_le_high_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cfg_q.sync_rd && !wr_op_i && lat_en_i) |=> $stable(hold));

  // R8
  write_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_op_i && lat_en_i) |=> $stable(hold));

  // R7
  sync_no_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cfg_q.sync_rd && !wr_op_i) |-> (addr_o == hold));

endmodule

// File: tb/fac_addr_capture_tb_top.sv
module fac_addr_capture_tb_top;

  localparam int AW = 8;
  localparam int MAXCYC = 150000;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic [AW-1:0] addr_i;
  logic          lat_en_i, sclk_i, sync_mode_i, fall_edge_i, wr_op_i, inhibit_i;
  logic [AW-1:0] addr_o;
  logic          addr_valid_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic [AW-1:0] exp_hold;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fac_addr_capture #(.AW(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .lat_en_i(lat_en_i),
    .sclk_i(sclk_i), .sync_mode_i(sync_mode_i), .fall_edge_i(fall_edge_i),
    .wr_op_i(wr_op_i), .inhibit_i(inhibit_i),
    .addr_o(addr_o), .addr_valid_o(addr_valid_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic le, input logic [AW-1:0] a, input logic k);
    @(negedge clk);
    lat_en_i = le; addr_i = a; sclk_i = k;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  initial begin
    wait (cyc >= MAXCYC);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, MAXCYC);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; addr_i = '0; lat_en_i = 1'b1; sclk_i = 1'b0;
    sync_mode_i = 1'b0; fall_edge_i = 1'b0; wr_op_i = 1'b0; inhibit_i = 1'b1;
    repeat (4) tick();
    chk("R1 addr in reset", addr_o, 0);
    chk("R1 valid in reset", addr_valid_o, 0);
    @(negedge clk); rst_ni = 1'b1;
    repeat (4) tick();
    chk("R1 addr after reset", addr_o, 0);
    chk("R1 valid after reset", addr_valid_o, 0);

    // R9: inhibit blocks transparency in async mode
    drive(1'b0, 8'h5A, 1'b0); tick();
    chk("R9 no open while inhibited", addr_o, 0);
    drive(1'b1, 8'h33, 1'b0); tick();
    chk("R9 no capture while inhibited", addr_o, 0);
    chk("R9 no valid while inhibited", addr_valid_o, 0);
    @(negedge clk); inhibit_i = 1'b0;
    tick();

    // R2 R3 R10: exhaustive async sweep
    for (int a = 0; a < 256; a++) begin
      drive(1'b0, AW'(a), 1'b0); tick();
      chk("R2 transparent", addr_o, a);
      chk("R10 no valid while open", addr_valid_o, 0);
      drive(1'b1, AW'(~a), 1'b1); tick();
      chk("R3 held at close", addr_o, a);
      chk("R10 valid after close", addr_valid_o, 1);
      drive(1'b1, AW'(a ^ 8'hA5), 1'b0); tick();
      chk("R3 held later", addr_o, a);
      chk("R10 valid one cycle", addr_valid_o, 0);
    end

    // R4: flow-through with strobe held low
    for (int i = 0; i < 8; i++) begin
      drive(1'b0, AW'(i * 37 + 3), 1'b0); tick();
      chk("R4 flow", addr_o, (i * 37 + 3) % 256);
      chk("R4 no valid", addr_valid_o, 0);
    end
    drive(1'b1, 8'hFF, 1'b0); tick();
    exp_hold = AW'(7 * 37 + 3);
    chk("R3 close after flow", addr_o, int'(exp_hold));

    // R5 R7: synchronous rising sweep
    @(negedge clk); sync_mode_i = 1'b1; fall_edge_i = 1'b0;
    repeat (2) tick();
    for (int a = 0; a < 256; a++) begin
      drive(1'b0, AW'(~a), 1'b0); tick();
      chk("R5 falling edge ignored", addr_o, int'(exp_hold));
      drive(1'b0, AW'(a), 1'b1); tick();
      exp_hold = AW'(a);
      chk("R5 rising capture", addr_o, a);
      chk("R10 sync valid", addr_valid_o, 1);
      drive(1'b0, AW'(a ^ 8'h3C), 1'b1); tick();
      chk("R7 no bypass", addr_o, a);
      chk("R10 sync valid one cycle", addr_valid_o, 0);
    end

    // R7 coincidence: edge together with strobe high
    drive(1'b0, 8'h11, 1'b0); tick();
    drive(1'b1, 8'h22, 1'b1); tick();
    chk("R7 edge with strobe high", addr_o, int'(exp_hold));
    chk("R7 no valid strobe high", addr_valid_o, 0);

    // R9 coincidence: edge together with inhibit
    drive(1'b0, 8'h44, 1'b0); tick();
    @(negedge clk); inhibit_i = 1'b1; addr_i = 8'h66; sclk_i = 1'b1;
    tick();
    chk("R9 sync edge inhibited", addr_o, int'(exp_hold));
    @(negedge clk); inhibit_i = 1'b0; sclk_i = 1'b0;
    tick();

    // R8 coincidence: write with closed strobe and edge
    @(negedge clk); wr_op_i = 1'b1; lat_en_i = 1'b1; sclk_i = 1'b1; addr_i = 8'h77;
    tick();
    chk("R8 edge ignored in write", addr_o, int'(exp_hold));
    chk("R8 no valid in write", addr_valid_o, 0);
    drive(1'b0, 8'h9C, 1'b0); tick();
    chk("R8 write transparent", addr_o, 8'h9C);
    drive(1'b1, 8'h01, 1'b1); tick();
    exp_hold = 8'h9C;
    chk("R8 write latched", addr_o, 8'h9C);
    chk("R8 write valid", addr_valid_o, 1);
    @(negedge clk); wr_op_i = 1'b0; sclk_i = 1'b1;
    tick();

    // R6: synchronous falling sweep
    @(negedge clk); fall_edge_i = 1'b1;
    repeat (2) tick();
    for (int a = 0; a < 256; a += 3) begin
      drive(1'b0, AW'(~a), 1'b1); tick();
      chk("R6 rising edge ignored", addr_o, int'(exp_hold));
      drive(1'b0, AW'(a), 1'b0); tick();
      exp_hold = AW'(a);
      chk("R6 falling capture", addr_o, a);
      chk("R6 valid", addr_valid_o, 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule